// File: doc/BRIEF.md
# Interrupt and Wake-up Controller for a Small 8-bit Core

This block collects the interrupt events of a small 8-bit microcontroller and turns them into a vector-fetch request and a wake-from-sleep pulse for the core. It has three sources. The first is a timer overflow pulse. The second is a change of state on any watched pin of an 8-bit input port. The third is a falling edge on port bit 0 when that pin works as the external interrupt input. It holds a three-bit flag register, a three-bit mask register and a global enable bit.

The core talks to the block through single-cycle strobes. There are strobes for enable, disable, return-from-interrupt, software interrupt, sleep, port read, flag write and mask write. When the core reads status it sees the flags ANDed with the mask. Port pins pass through a synchronizer before edge and change detection. A port read captures the reference that the change detector compares against. While the core sleeps, a watched port change wakes it. After waking, the core either resumes in line or vectors, depending on the global enable.

Top module: `intWakeCtrl`

## Requirements
- R1: Flag bit positions are: bit 0 timer, bit 1 port change, bit 2 external pin. A timer pulse or an external event sets its flag at the next clock edge, whatever the mask and global enable hold.
- R2: The port-change flag (bit 1) is set by a detected change only while mask bit 1 is 1.
- R3: `statusRd` always equals flags AND mask. A flag write loads `regWrData` into the flags. A mask write loads it into the mask. An event in the same cycle as a flag write still leaves its flag set.
- R4: `globalEn` is 0 after reset. It becomes 1 one edge after an enable or return-from-interrupt strobe. It becomes 0 one edge after a disable strobe.
- R5: When `globalEn` is 1, the core is awake and (flags AND mask) is nonzero, the next edge raises `vecReq` for one cycle with `vecAddr` = 0x008 and clears `globalEn`.
- R6: A software interrupt strobe raises `vecReq` at the next edge with `vecAddr` = 0x001 and clears `globalEn`, whatever `globalEn` held.
- R7: Vectoring never clears a flag. A flag left set vectors again once `globalEn` returns.
- R8: Pins pass through two synchronizer stages. A port read loads the change reference from the synchronized pins. A difference on a watched pin sets the change flag on the third edge after the pin moves, and the reference then follows the new value.
- R9: Pins marked as outputs in `portIsOutput`, and bit 0 while `extIntMode` is 1, never cause a port-change event.
- R10: With `extIntMode` = 1, a high-to-low transition on synchronized bit 0 sets the external flag on the third edge after the pin falls. A rising transition sets nothing.
- R11: A sleep strobe puts the block to sleep, and no hardware vector is issued while asleep. A change that sets the port-change flag while asleep gives a one-cycle `wakeUp` pulse on that same edge and ends sleep. A vector at 0x008 follows one edge later only if `globalEn` is 1.
- R12: After reset, flags, mask, `statusRd`, `vecReq`, `wakeUp` and `asleep` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerOvf | input | 1 | Timer overflow pulse, synchronous to clk |
| portPins | input | 8 | Asynchronous port pin levels |
| portIsOutput | input | 8 | 1 marks a pin driven as output |
| extIntMode | input | 1 | Bit 0 acts as external interrupt pin |
| enStrobe | input | 1 | Set global enable |
| disStrobe | input | 1 | Clear global enable |
| retiStrobe | input | 1 | Return from interrupt, sets global enable |
| swIntStrobe | input | 1 | Software interrupt |
| sleepStrobe | input | 1 | Enter sleep |
| portRead | input | 1 | Port read, loads change reference |
| flagWrStrobe | input | 1 | Write flag register |
| maskWrStrobe | input | 1 | Write mask register |
| regWrData | input | 3 | Data for flag or mask write |
| statusRd | output | 3 | Flags AND mask |
| vecReq | output | 1 | One-cycle vector fetch request |
| vecAddr | output | 10 | Vector address for the request |
| wakeUp | output | 1 | One-cycle wake pulse |
| globalEn | output | 1 | Global interrupt enable |
| asleep | output | 1 | Core is in sleep |

## Verification
On every cycle, the embedded properties check several rules. A timer pulse always lands in its flag. The change flag never rises with its mask bit clear, unless software writes it. Flags stay still when no write or event occurs. An external event lasts a single clock. A vector request always comes with the global enable cleared. A disable always takes effect. A wake pulse always marks the end of sleep. Only the bench scenarios can show the full latencies through the synchronizer, the exclusion of output pins and of bit 0 in external mode, the re-trigger after return, and the choice between in-line resume and vectoring after a wake.

// File: rtl/iwcPkg.sv
package iwcPkg;
  localparam int FLAG_W  = 3;
  localparam int TMR_BIT = 0;
  localparam int CHG_BIT = 1;
  localparam int EXT_BIT = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic flagWr;
    logic maskWr;
    logic refLoad;
  } dpCtrl_t;

  // summary from datapath to control
  typedef struct packed {
    logic pending;
    logic chgWake;
  } dpStat_t;
endpackage

// File: rtl/iwcDatapath.sv
module iwcDatapath
  import iwcPkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              timerOvf,
  input  logic [PORT_W-1:0] portPins,
  input  logic [PORT_W-1:0] portIsOutput,
  input  logic              extIntMode,
  input  logic [FLAG_W-1:0] regWrData,
  output logic [FLAG_W-1:0] statusRd,
  output dpStat_t           stat
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PORT_W-1:0] syncQ [SYNC_STAGES];
  logic [PORT_W-1:0] pinNow, refQ, watchMask;
  logic              pinPrev0;
  logic              chgEvt, extEvt;
  logic [FLAG_W-1:0] flagsQ, maskQ, setVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= portPins;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign pinNow    = syncQ[LAST];
  assign watchMask = ~portIsOutput & ~{{(PORT_W-1){1'b0}}, extIntMode};
  assign chgEvt    = |((pinNow ^ refQ) & watchMask);
  assign extEvt    = extIntMode & pinPrev0 & ~pinNow[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ     <= '0;
      pinPrev0 <= 1'b0;
    end else begin
      if (ctrl.refLoad || chgEvt) refQ <= pinNow;
      pinPrev0 <= pinNow[0];
    end
  end

  always_comb begin
    setVec          = '0;
    setVec[TMR_BIT] = timerOvf;
    setVec[CHG_BIT] = chgEvt & maskQ[CHG_BIT];
    setVec[EXT_BIT] = extEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      maskQ  <= '0;
    end else begin
      flagsQ <= (ctrl.flagWr ? regWrData : flagsQ) | setVec;
      if (ctrl.maskWr) maskQ <= regWrData;
    end
  end

  assign statusRd     = flagsQ & maskQ;
  assign stat.pending = |statusRd;
  assign stat.chgWake = setVec[CHG_BIT];

  a_r1_timer_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |=> flagsQ[TMR_BIT]);

  a_r2_chg_needs_mask: assert property (@(posedge clk) disable iff (!rstN)
    (!maskQ[CHG_BIT] && !ctrl.flagWr) |=> !$rose(flagsQ[CHG_BIT]));

  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.flagWr && !timerOvf && !chgEvt && !extEvt) |=> $stable(flagsQ));

  a_r10_ext_single_clock: assert property (@(posedge clk) disable iff (!rstN)
    extEvt |=> !extEvt);
endmodule

// File: rtl/iwcControl.sv
module iwcControl
  import iwcPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int HW_VEC = 8,
  parameter int SW_VEC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enStrobe,
  input  logic              disStrobe,
  input  logic              retiStrobe,
  input  logic              swIntStrobe,
  input  logic              sleepStrobe,
  input  logic              portRead,
  input  logic              flagWrStrobe,
  input  logic              maskWrStrobe,
  input  dpStat_t           stat,
  output dpCtrl_t           ctrl,
  output logic              vecReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              wakeUp,
  output logic              globalEn,
  output logic              asleep
);
  localparam logic [ADDR_W-1:0] HW_ADDR = ADDR_W'(HW_VEC);
  localparam logic [ADDR_W-1:0] SW_ADDR = ADDR_W'(SW_VEC);

  logic takeHw;

  assign ctrl.flagWr  = flagWrStrobe;
  assign ctrl.maskWr  = maskWrStrobe;
  assign ctrl.refLoad = portRead;

  assign takeHw = globalEn & ~asleep & stat.pending & ~swIntStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReq   <= 1'b0;
      vecAddr  <= '0;
      globalEn <= 1'b0;
      asleep   <= 1'b0;
      wakeUp   <= 1'b0;
    end else begin
      vecReq <= swIntStrobe | takeHw;
      if (swIntStrobe)  vecAddr <= SW_ADDR;
      else if (takeHw)  vecAddr <= HW_ADDR;

      if (swIntStrobe || takeHw || disStrobe) globalEn <= 1'b0;
      else if (enStrobe || retiStrobe)        globalEn <= 1'b1;

      wakeUp <= asleep & stat.chgWake;
      if (asleep && stat.chgWake) asleep <= 1'b0;
      else if (sleepStrobe)       asleep <= 1'b1;
    end
  end

  a_r5_vec_clears_enable: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> !globalEn);

  a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    disStrobe |=> !globalEn);

  a_r11_wake_ends_sleep: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> (!asleep && $past(asleep)));
endmodule

// File: rtl/intWakeCtrl.sv
module intWakeCtrl
  import iwcPkg::*;
#(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerOvf,
  input  logic [PORT_W-1:0] portPins,
  input  logic [PORT_W-1:0] portIsOutput,
  input  logic              extIntMode,
  input  logic              enStrobe,
  input  logic              disStrobe,
  input  logic              retiStrobe,
  input  logic              swIntStrobe,
  input  logic              sleepStrobe,
  input  logic              portRead,
  input  logic              flagWrStrobe,
  input  logic              maskWrStrobe,
  input  logic [FLAG_W-1:0] regWrData,
  output logic [FLAG_W-1:0] statusRd,
  output logic              vecReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              wakeUp,
  output logic              globalEn,
  output logic              asleep
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  iwcDatapath #(.PORT_W(PORT_W), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .timerOvf(timerOvf),
    .portPins(portPins), .portIsOutput(portIsOutput), .extIntMode(extIntMode),
    .regWrData(regWrData), .statusRd(statusRd), .stat(stat)
  );

  iwcControl #(.ADDR_W(ADDR_W), .HW_VEC(8), .SW_VEC(1)) u_ctl (
    .clk(clk), .rstN(rstN), .enStrobe(enStrobe), .disStrobe(disStrobe),
    .retiStrobe(retiStrobe), .swIntStrobe(swIntStrobe), .sleepStrobe(sleepStrobe),
    .portRead(portRead), .flagWrStrobe(flagWrStrobe), .maskWrStrobe(maskWrStrobe),
    .stat(stat), .ctrl(ctrl), .vecReq(vecReq), .vecAddr(vecAddr),
    .wakeUp(wakeUp), .globalEn(globalEn), .asleep(asleep)
  );
endmodule

// File: tb/intWakeCtrl_tb.sv
module intWakeCtrl_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       timerOvf, extIntMode;
  logic [7:0] portPins, portIsOutput;
  logic       enStrobe, disStrobe, retiStrobe, swIntStrobe, sleepStrobe;
  logic       portRead, flagWrStrobe, maskWrStrobe;
  logic [2:0] regWrData, statusRd;
  logic       vecReq, wakeUp, globalEn, asleep;
  logic [9:0] vecAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  intWakeCtrl u_dut (
    .clk(clk), .rstN(rstN), .timerOvf(timerOvf), .portPins(portPins),
    .portIsOutput(portIsOutput), .extIntMode(extIntMode), .enStrobe(enStrobe),
    .disStrobe(disStrobe), .retiStrobe(retiStrobe), .swIntStrobe(swIntStrobe),
    .sleepStrobe(sleepStrobe), .portRead(portRead), .flagWrStrobe(flagWrStrobe),
    .maskWrStrobe(maskWrStrobe), .regWrData(regWrData), .statusRd(statusRd),
    .vecReq(vecReq), .vecAddr(vecAddr), .wakeUp(wakeUp), .globalEn(globalEn),
    .asleep(asleep)
  );

  // flags, mask, expected status
  localparam logic [8:0] TBL [6] = '{
    {3'b111, 3'b000, 3'b000},
    {3'b111, 3'b111, 3'b111},
    {3'b101, 3'b110, 3'b100},
    {3'b010, 3'b011, 3'b010},
    {3'b011, 3'b101, 3'b001},
    {3'b000, 3'b111, 3'b000}
  };

  task automatic step(); @(negedge clk); endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrFlags(logic [2:0] d);
    regWrData = d; flagWrStrobe = 1'b1; step(); flagWrStrobe = 1'b0;
  endtask
  task automatic wrMask(logic [2:0] d);
    regWrData = d; maskWrStrobe = 1'b1; step(); maskWrStrobe = 1'b0;
  endtask
  task automatic doRead();  portRead = 1'b1;    step(); portRead = 1'b0;    endtask
  task automatic doEn();    enStrobe = 1'b1;    step(); enStrobe = 1'b0;    endtask
  task automatic doTimer(); timerOvf = 1'b1;    step(); timerOvf = 1'b0;    endtask
  task automatic doSleep(); sleepStrobe = 1'b1; step(); sleepStrobe = 1'b0; endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; timerOvf = 0; extIntMode = 0; portPins = 8'hFF; portIsOutput = 0;
    enStrobe = 0; disStrobe = 0; retiStrobe = 0; swIntStrobe = 0; sleepStrobe = 0;
    portRead = 0; flagWrStrobe = 0; maskWrStrobe = 0; regWrData = 0;
    step(); step(); rstN = 1'b1; step();

    // R12 reset state
    check("R12 status", 16'(statusRd), 0);
    check("R12 vecReq", 16'(vecReq), 0);
    check("R12 wakeUp", 16'(wakeUp), 0);
    check("R12 asleep", 16'(asleep), 0);
    check("R4 reset enable", 16'(globalEn), 0);

    // R3 table of flag/mask writes
    foreach (TBL[i]) begin
      wrFlags(TBL[i][8:6]);
      wrMask(TBL[i][5:3]);
      check("R3 status table", 16'(statusRd), 16'(TBL[i][2:0]));
    end
    wrFlags(0); wrMask(0);

    // R1 timer flag latches while masked
    doTimer();
    check("R3 masked status", 16'(statusRd), 0);
    wrMask(3'b111);
    check("R1 timer flag", 16'(statusRd), 16'b001);
    wrFlags(0);

    // R2 change with mask bit 1 clear sets nothing
    wrMask(0); doRead();
    portPins = 8'hF7; step(); step(); step();
    wrMask(3'b010);
    check("R2 change masked", 16'(statusRd), 0);

    // R8 change detection latency
    doRead();
    portPins = 8'hD7; step(); step();
    check("R8 not yet", 16'(statusRd), 0);
    step();
    check("R8 change flag", 16'(statusRd), 16'b010);
    wrFlags(0);

    // R9 output pin excluded
    portIsOutput = 8'h10; portPins = 8'hC7;
    step(); step(); step(); step();
    check("R9 output pin", 16'(statusRd), 0);
    doRead(); portIsOutput = 0; step(); step();
    check("R9 rearm", 16'(statusRd), 0);

    // R10 external falling edge, R9 bit0 excluded from change
    extIntMode = 1'b1; wrMask(3'b110); doRead();
    portPins = 8'hC6; step(); step();
    check("R10 not yet", 16'(statusRd), 0);
    step();
    check("R10 ext flag", 16'(statusRd), 16'b100);
    wrFlags(0);
    portPins = 8'hC7; step(); step(); step(); step();
    check("R10 rising ignored", 16'(statusRd), 0);
    extIntMode = 1'b0; doRead();

    // R4/R5/R7 vectoring
    wrMask(3'b001); doTimer();
    doEn();
    check("R4 enable set", 16'(globalEn), 1);
    check("R5 not yet", 16'(vecReq), 0);
    step();
    check("R5 vecReq", 16'(vecReq), 1);
    check("R5 vecAddr", 16'(vecAddr), 16'h008);
    check("R5 enable cleared", 16'(globalEn), 0);
    step();
    check("R5 single pulse", 16'(vecReq), 0);
    check("R7 flag kept", 16'(statusRd), 16'b001);
    retiStrobe = 1'b1; step(); retiStrobe = 1'b0;
    check("R4 reti sets", 16'(globalEn), 1);
    step();
    check("R7 retrigger", 16'(vecReq), 1);
    wrFlags(0);

    // R4 disable
    doEn();
    check("R4 enable again", 16'(globalEn), 1);
    disStrobe = 1'b1; step(); disStrobe = 1'b0;
    check("R4 disable", 16'(globalEn), 0);

    // R6 software interrupt
    swIntStrobe = 1'b1; step(); swIntStrobe = 1'b0;
    check("R6 vecReq", 16'(vecReq), 1);
    check("R6 vecAddr", 16'(vecAddr), 16'h001);
    check("R6 enable", 16'(globalEn), 0);

    // R3 event wins over same-cycle flag write
    regWrData = 0; flagWrStrobe = 1'b1; timerOvf = 1'b1; step();
    flagWrStrobe = 1'b0; timerOvf = 1'b0;
    check("R3 event beats write", 16'(statusRd), 16'b001);
    wrFlags(0);

    // R11 wake with enable clear: in line
    wrMask(3'b010); doRead(); doSleep();
    check("R11 asleep", 16'(asleep), 1);
    portPins = 8'h87; step(); step();
    check("R11 no wake yet", 16'(wakeUp), 0);
    step();
    check("R11 wake", 16'(wakeUp), 1);
    check("R11 woke", 16'(asleep), 0);
    check("R11 flag", 16'(statusRd), 16'b010);
    step();
    check("R11 wake pulse", 16'(wakeUp), 0);
    check("R11 in line", 16'(vecReq), 0);
    wrFlags(0);

    // R11 wake with enable set: vector after wake
    wrMask(3'b011); doRead(); doEn(); doSleep();
    doTimer(); step();
    check("R11 no vector asleep", 16'(vecReq), 0);
    portPins = 8'hC7; step(); step(); step();
    check("R11 wake2", 16'(wakeUp), 1);
    check("R11 vec not yet", 16'(vecReq), 0);
    step();
    check("R11 vector", 16'(vecReq), 1);
    check("R11 vector addr", 16'(vecAddr), 16'h008);

    finish();
  end
endmodule